// File: doc/BRIEF.md
# Dual Register Select-Compare Unit

The unit keeps two independent 4-bit shift registers, A and B, each filled one bit at a time through its own serial input. Each register has its own shift enable and its own clear. All of them run on one shared clock, so either register can be loaded while the other keeps its word.

The two parallel words feed a combinational stage that works on every bit position at once. All positions share the same controls. A two-bit select picks zero, word B, word A, or the bitwise equality of A and B. An invert bit then flips every result bit, which gives eight output functions in total. An equal flag goes high when the equality function is selected without inversion and every bit agrees, so the block can act as a word comparator.

Top module: `dual_reg_select_cmp`

## Requirements
- R1: While `rst_n` is low, both registers are cleared to zero. After reset, the output `q` reads 0 with `sel_a`=1, `sel_b`=0 and `inv`=0, and it also reads 0 with `sel_a`=0, `sel_b`=1 and `inv`=0.
- R2: On a rising clock edge with `shift_x` high and `clr_x` low, register x loads its serial input into stage 0. Each stage k (k = 1..3) takes the old value of stage k-1, and the old stage 3 value is dropped. Stage n of register A drives bit n of word A, and stage n of register B drives bit n of word B.
- R3: On an edge with `shift_x` low and `clr_x` low, register x keeps its value, whatever the other register is doing.
- R4: On an edge with `clr_x` high, register x becomes zero, even when `shift_x` is also high.
- R5: With `sel_a`=0 and `sel_b`=0, `q` is all zeros when `inv`=0 and all ones when `inv`=1.
- R6: With `sel_a`=0 and `sel_b`=1, `q` equals word B when `inv`=0 and the bitwise complement of B when `inv`=1.
- R7: With `sel_a`=1 and `sel_b`=0, `q` equals word A when `inv`=0 and the bitwise complement of A when `inv`=1.
- R8: With `sel_a`=1 and `sel_b`=1, `q` is A XNOR B when `inv`=0 and A XOR B when `inv`=1.
- R9: `q` follows a change of `sel_a`, `sel_b` or `inv` in the same cycle, with no clock edge in between.
- R10: `match` is 1 exactly when `sel_a`=1, `sel_b`=1, `inv`=0 and all bits of `q` are 1, that is, when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| ser_a | input | 1 | Serial data into register A |
| shift_a | input | 1 | Shift enable of register A |
| clr_a | input | 1 | Synchronous clear of register A |
| ser_b | input | 1 | Serial data into register B |
| shift_b | input | 1 | Shift enable of register B |
| clr_b | input | 1 | Synchronous clear of register B |
| sel_a | input | 1 | Function select, upper bit |
| sel_b | input | 1 | Function select, lower bit |
| inv | input | 1 | Inverts every result bit |
| q | output | 4 | Selected and optionally inverted result |
| match | output | 1 | High when the equality function shows full agreement |

## Verification
The bench loads A and B serially and then sweeps all eight control codes against the loaded words.
- A swapped select decode shows up as A where B was expected.
- An invert that is missing or placed on the wrong function breaks the all-ones code or the XOR code.
- A register that shifts in the wrong direction reads back as a bit-reversed word.

Loading B while A holds would expose a shared enable. Asserting clear together with shift catches a design that gives shift priority over clear. Changing the controls without a clock edge catches a design that registers the output. The equal flag is checked on identical words, on words that differ in one bit, and under the XOR code, where it must stay low.

// File: rtl/dual_reg_select_cmp.sv
module dual_reg_select_cmp #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_a,
  input  logic             shift_a,
  input  logic             clr_a,
  input  logic             ser_b,
  input  logic             shift_b,
  input  logic             clr_b,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             inv,
  output logic [WIDTH-1:0] q,
  output logic             match
);

  logic [WIDTH-1:0] reg_a, reg_b, fn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_a <= '0;
    else if (clr_a)   reg_a <= '0;
    else if (shift_a) reg_a <= {reg_a[WIDTH-2:0], ser_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_b <= '0;
    else if (clr_b)   reg_b <= '0;
    else if (shift_b) reg_b <= {reg_b[WIDTH-2:0], ser_b};
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case ({sel_a, sel_b})
        2'b00:   fn[i] = 1'b0;
        2'b01:   fn[i] = reg_b[i];
        2'b10:   fn[i] = reg_a[i];
        default: fn[i] = ~(reg_a[i] ^ reg_b[i]);
      endcase
    end
  end

  assign q     = fn ^ {WIDTH{inv}};
  assign match = sel_a & sel_b & ~inv & (&q);

  // R2
  shift_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_a && !clr_a) |=> (reg_a[0] == $past(ser_a) && reg_a[WIDTH-1:1] == $past(reg_a[WIDTH-2:0])));
  // R3
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_b && !clr_b) |=> $stable(reg_b));
  // R4
  clr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a |=> (reg_a == '0));
  // R5
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a && !sel_b) |-> ($countones(q) == (inv ? WIDTH : 0)));
  // R10
  match_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (reg_a == reg_b));

endmodule

// File: tb/test_dual_reg_select_cmp.sv
module test_dual_reg_select_cmp;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic ser_a = 0, shift_a = 0, clr_a = 0, ser_b = 0, shift_b = 0, clr_b = 0;
  logic sel_a = 0, sel_b = 0, inv = 0;
  logic [W-1:0] q;
  logic match;
  logic [W-1:0] ma, mb;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dual_reg_select_cmp #(.WIDTH(W)) i_dual_reg_select_cmp (
    .clk(clk), .rst_n(rst_n), .ser_a(ser_a), .shift_a(shift_a), .clr_a(clr_a),
    .ser_b(ser_b), .shift_b(shift_b), .clr_b(clr_b), .sel_a(sel_a), .sel_b(sel_b),
    .inv(inv), .q(q), .match(match));

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_q(logic sa, logic sb, logic iv, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] f;
    case ({sa, sb})
      2'b00: f = '0;
      2'b01: f = b;
      2'b10: f = a;
      default: f = ~(a ^ b);
    endcase
    return f ^ {W{iv}};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_code(logic sa, logic sb, logic iv);
    sel_a = sa; sel_b = sb; inv = iv; #1;
  endtask

  task automatic load_a(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      ser_a = w[i]; shift_a = 1; tick();
    end
    shift_a = 0; ma = w;
  endtask

  task automatic load_b(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      ser_b = w[i]; shift_b = 1; tick();
    end
    shift_b = 0; mb = w;
  endtask

  task automatic t_reset();
    set_code(1, 0, 0); check("R1 reset A", q, '0);
    set_code(0, 1, 0); check("R1 reset B", q, '0);
  endtask

  task automatic t_shift();
    ser_a = 1; shift_a = 1; tick(); shift_a = 0;
    set_code(1, 0, 0); check("R2 first stage", q, 4'b0001);
    ser_a = 0; shift_a = 1; tick(); ser_a = 1; tick(); shift_a = 0;
    check("R2 order", q, 4'b0101);
    ser_a = 0; shift_a = 1; tick(); ser_a = 0; tick(); shift_a = 0;
    check("R2 drop stage3", q, 4'b0100);
    ma = 4'b0100;
  endtask

  task automatic t_hold();
    load_b(4'b1011);
    set_code(1, 0, 0); check("R3 A holds while B loads", q, ma);
    tick(); tick();
    set_code(0, 1, 0); check("R3 B holds idle", q, 4'b1011);
    set_code(0, 1, 1); check("R6 B inverted", q, 4'b0100);
  endtask

  task automatic t_clear();
    ser_a = 1; shift_a = 1; clr_a = 1; tick(); shift_a = 0; clr_a = 0; ma = '0;
    set_code(1, 0, 0); check("R4 clear over shift", q, '0);
    set_code(0, 1, 0); check("R4 B untouched", q, mb);
    clr_b = 1; tick(); clr_b = 0; mb = '0;
    check("R4 clear B", q, '0);
  endtask

  task automatic t_sweep(int rounds);
    for (int r = 0; r < rounds; r++) begin
      load_a(W'($urandom));
      load_b(W'($urandom));
      for (int c = 0; c < 8; c++) begin
        logic [2:0] cc;
        cc = 3'(c);
        set_code(cc[2], cc[1], cc[0]);
        case (cc[2:1])
          2'b00: check("R5 code sweep", q, ref_q(cc[2], cc[1], cc[0], ma, mb));
          2'b01: check("R6 code sweep", q, ref_q(cc[2], cc[1], cc[0], ma, mb));
          2'b10: check("R7 code sweep", q, ref_q(cc[2], cc[1], cc[0], ma, mb));
          default: check("R8 code sweep", q, ref_q(cc[2], cc[1], cc[0], ma, mb));
        endcase
        check("R10 flag sweep", {3'b0, match}, {3'b0, (cc == 3'b110) && (ma == mb)});
      end
    end
  endtask

  task automatic t_comb();
    load_a(4'b0110); load_b(4'b0011);
    @(posedge clk); #2;
    set_code(1, 0, 1); check("R9 same-cycle A inv", q, 4'b1001);
    set_code(1, 1, 1); check("R9 same-cycle xor", q, 4'b0101);
    set_code(0, 0, 1); check("R9 same-cycle ones", q, 4'b1111);
  endtask

  task automatic t_match();
    load_a(4'b1001); load_b(4'b1001);
    set_code(1, 1, 0); check("R10 equal words", {3'b0, match}, 4'b0001);
    check("R8 xnor equal", q, 4'b1111);
    set_code(1, 1, 1); check("R10 xor code no flag", {3'b0, match}, 4'b0000);
    load_b(4'b1000);
    set_code(1, 1, 0); check("R10 one-bit diff", {3'b0, match}, 4'b0000);
    check("R8 xnor diff", q, 4'b1110);
  endtask

  initial begin
    ma = '0; mb = '0;
    #20; rst_n = 1; #1;
    tick();
    t_reset();
    t_shift();
    t_hold();
    t_clear();
    t_sweep(12);
    t_comb();
    t_match();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule